// File: doc/BRIEF.md
# Sweeping Single-Engine Spare Allocator for Word-Oriented Memory Repair

This block decides how to repair a word-oriented memory that has a fixed set of spare rows and spare columns. A self-test engine reads the memory and, on each read, presents a fail flag, the row address and a per-bit miscompare vector as wide as the data word. The block follows one allocation ordering at a time. An ordering is a sequence of R and C tokens with as many R tokens as spare rows and as many C tokens as spare columns. Each uncovered failure takes the next token. A row token records the failing row in the next free row slot. A column token merges the failing bits into a column repair vector (CRV) that has one bit per data bit.

When the current ordering cannot cover a failure, the block moves to the next ordering in lexicographic order (R before C). It clears its repair state and pulses a restart request so that the test engine runs again. If a test run finishes while an ordering still holds, the block reports success and keeps the row slots and the CRV as the repair data. If every ordering fails, it reports the memory as not repairable. All orderings share one engine, so the storage cost is that of a single ordering. The price is one extra test run for each failed ordering.

Top module: `spare_sweep_analyzer`

## Requirements
- R1: After reset the block is idle, with busy, restart, repair_ok and unrepairable all low. A start pulse selects strategy index 0, clears the CRV and all row slots, and raises busy from the next cycle.
- R2: An uncovered failure takes the token at the current position of the ordering, and the position advances by exactly one. A C token ORs fail_bits into crv. An R token writes fail_row into the lowest unused row slot and sets that slot's bit in row_used. Slot i occupies bits [i*ROW_AW +: ROW_AW] of row_list.
- R3: A failure is covered, and changes neither crv, row_used nor row_list, when its set bits are a subset of crv or when its row equals a row already held in a used slot.
- R4: A cycle with fail_vld low, a failure whose fail_bits are all zero, and any input while restart is high all leave the repair state unchanged.
- R5: An uncovered failure that arrives after every token of the ordering has been used fails the ordering.
- R6: A C token whose merge would leave more than COLS_SP ones in crv fails the ordering, and that merge is not kept. While busy, crv never holds more than COLS_SP ones.
- R7: When an ordering fails and it is not the last one, restart is high for exactly one cycle, beginning in the cycle after the failing input. At the same time crv and row_used are cleared and the next ordering is selected.
- R8: A run_done pulse in the running state, with no failing ordering in that cycle, sets repair_ok and clears busy. crv and row_list then stay unchanged until the next start.
- R9: When the last ordering fails, unrepairable is set, busy is cleared, and restart is not pulsed. repair_ok and unrepairable are never high together.
- R10: strat_code shows the current ordering with bit ROWS_SP+COLS_SP-1 as the first token, 1 meaning column and 0 meaning row. strat_idx counts the orderings from 0. For two rows and two columns, the codes in order are 0011, 0101, 0110, 1001, 1010, 1100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new analysis with the first ordering |
| fail_vld | input | 1 | A compared read is presented this cycle |
| fail_row | input | ROW_AW | Row address of the compared read |
| fail_bits | input | WORD_W | Per-bit miscompare vector of the read |
| run_done | input | 1 | The test engine finished its current run |
| busy | output | 1 | Analysis in progress |
| restart | output | 1 | One-cycle request to rerun the test engine |
| repair_ok | output | 1 | The current ordering covers every failure seen |
| unrepairable | output | 1 | Every ordering has failed |
| strat_code | output | ROWS_SP+COLS_SP | Current ordering, first token in the top bit, 1 = column |
| strat_idx | output | SIW | Index of the current ordering |
| crv | output | WORD_W | Column repair vector |
| row_list | output | ROWS_SP*ROW_AW | Allocated row addresses, one slot per spare row |
| row_used | output | ROWS_SP | Valid flag for each row slot |

## Verification
The first pattern mixes single-bit and multi-bit failures, repeats failures on an allocated row and inside the CRV, and adds a read with no failing bits. It separates real allocation from coverage and from ignored input. The second pattern is a wide miscompare followed by two identical multi-bit failures. Under row-first orderings this overflows the CRV, and only the fourth ordering (C R R C) covers it. The test therefore shows the restart pulse, the clearing of state and the lexicographic order, and it confirms that the final row slots and CRV come from the successful ordering. The third pattern is five single-bit failures on distinct rows and columns. It runs out of tokens under every ordering and must end as unrepairable after exactly five restarts.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RUN     = 3'd1,
      ST_RESTART = 3'd2,
      ST_PASS    = 3'd3,
      ST_FAIL    = 3'd4
   } ssa_state_e;

   function automatic int unsigned ones64(input logic [63:0] v);
      int unsigned c;
      c = 0;
      for (int i = 0; i < 64; i++) c += int'(v[i]);
      return c;
   endfunction

   function automatic int unsigned ctz64(input logic [63:0] v);
      int unsigned z;
      z = 64;
      for (int i = 63; i >= 0; i--) if (v[i]) z = i;
      return z;
   endfunction

   function automatic int unsigned choose(input int unsigned n, input int unsigned k);
      longint unsigned r;
      r = 1;
      for (int unsigned i = 1; i <= k; i++) r = r * (n - k + i) / i;
      return int'(r);
   endfunction

endpackage

// File: rtl/ssa_strategy_seq.sv
module ssa_strategy_seq
   import ssa_pkg::*;
#(
   parameter int T    = 4,
   parameter int NCOL = 2,
   parameter int SIW  = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_first,
   input  logic           advance,
   output logic [T-1:0]   code,
   output logic [SIW-1:0] idx,
   output logic           is_last
);
   localparam logic [T-1:0] FIRST = T'((64'd1 << NCOL) - 64'd1);
   localparam logic [T-1:0] LAST  = FIRST << (T - NCOL);

   logic [T-1:0] lowbit, rsum, nxt;

   // next combination with the same number of column tokens
   always_comb begin
      lowbit = code & (~code + 1'b1);
      rsum   = code + lowbit;
      nxt    = rsum | ((code ^ rsum) >> (ctz64(64'(code)) + 2));
   end

   assign is_last = (code == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= FIRST;
         idx  <= '0;
      end else if (load_first) begin
         code <= FIRST;
         idx  <= '0;
      end else if (advance && !is_last) begin
         code <= nxt;
         idx  <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/ssa_spare_alloc.sv
module ssa_spare_alloc
   import ssa_pkg::*;
#(
   parameter int NROW = 2,
   parameter int NCOL = 2,
   parameter int RAW  = 4,
   parameter int WW   = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                enable,
   input  logic                fail_vld,
   input  logic [RAW-1:0]      fail_row,
   input  logic [WW-1:0]       fail_bits,
   input  logic [NROW+NCOL-1:0] code,
   output logic [WW-1:0]       crv,
   output logic [NROW*RAW-1:0] row_list,
   output logic [NROW-1:0]     row_used,
   output logic                strat_fail
);
   localparam int T  = NROW + NCOL;
   localparam int PW = $clog2(T + 1);
   localparam int RW = (NROW < 2) ? 1 : $clog2(NROW);

   logic [PW-1:0]   ptr;
   logic [RW-1:0]   rcnt;
   logic [NROW-1:0] hit_v;
   logic [NROW-1:0] wr_slot;
   logic            row_hit, need, exhausted, tok_col, over, commit;
   logic [WW-1:0]   crv_or;

   for (genvar i = 0; i < NROW; i++) begin : g_hit
      assign hit_v[i] = row_used[i] && (row_list[i*RAW +: RAW] == fail_row);
   end
   assign row_hit = |hit_v;

   always_comb begin
      tok_col = 1'b0;
      for (int k = 0; k < T; k++) if (ptr == PW'(k)) tok_col = code[T-1-k];
   end

   assign exhausted  = (ptr == PW'(T));
   assign crv_or     = crv | fail_bits;
   assign over       = ones64(64'(crv_or)) > NCOL;
   assign need       = enable && fail_vld && (|(fail_bits & ~crv)) && !row_hit;
   assign strat_fail = need && (exhausted || (tok_col && over));
   assign commit     = need && !strat_fail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr  <= '0;
         rcnt <= '0;
         crv  <= '0;
      end else if (clear) begin
         ptr  <= '0;
         rcnt <= '0;
         crv  <= '0;
      end else if (commit) begin
         ptr <= ptr + 1'b1;
         if (tok_col) crv  <= crv_or;
         else         rcnt <= rcnt + 1'b1;
      end
   end

   for (genvar i = 0; i < NROW; i++) begin : g_slot
      assign wr_slot[i] = commit && !tok_col && (rcnt == RW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row_used[i]              <= 1'b0;
            row_list[i*RAW +: RAW]   <= '0;
         end else if (clear) begin
            row_used[i]              <= 1'b0;
            row_list[i*RAW +: RAW]   <= '0;
         end else if (wr_slot[i]) begin
            row_used[i]              <= 1'b1;
            row_list[i*RAW +: RAW]   <= fail_row;
         end
      end
   end
endmodule

// File: rtl/spare_sweep_analyzer.sv
module spare_sweep_analyzer
   import ssa_pkg::*;
#(
   parameter int ROWS_SP = 2,
   parameter int COLS_SP = 2,
   parameter int ROW_AW  = 4,
   parameter int WORD_W  = 5,
   localparam int T      = ROWS_SP + COLS_SP,
   localparam int NSTRAT = choose(T, ROWS_SP),
   localparam int SIW    = (NSTRAT < 2) ? 1 : $clog2(NSTRAT)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   fail_vld,
   input  logic [ROW_AW-1:0]      fail_row,
   input  logic [WORD_W-1:0]      fail_bits,
   input  logic                   run_done,
   output logic                   busy,
   output logic                   restart,
   output logic                   repair_ok,
   output logic                   unrepairable,
   output logic [T-1:0]           strat_code,
   output logic [SIW-1:0]         strat_idx,
   output logic [WORD_W-1:0]      crv,
   output logic [ROWS_SP*ROW_AW-1:0] row_list,
   output logic [ROWS_SP-1:0]     row_used
);
   if (ROWS_SP < 1 || COLS_SP < 1) begin : g_bad_spares
      $error("spare_sweep_analyzer: needs at least one spare row and one spare column");
   end
   if (T > 16) begin : g_bad_total
      $error("spare_sweep_analyzer: at most 16 spares in total");
   end
   if (COLS_SP > WORD_W || WORD_W > 64) begin : g_bad_word
      $error("spare_sweep_analyzer: WORD_W must be in COLS_SP..64");
   end

   ssa_state_e state, state_nx;
   logic strat_fail, is_last, load_first, advance, clear;

   always_comb begin
      state_nx   = state;
      load_first = 1'b0;
      advance    = 1'b0;
      clear      = 1'b0;
      if (start) begin
         state_nx   = ST_RUN;
         load_first = 1'b1;
         clear      = 1'b1;
      end else begin
         unique case (state)
            ST_RUN: begin
               if (strat_fail) begin
                  clear    = 1'b1;
                  state_nx = is_last ? ST_FAIL : ST_RESTART;
                  advance  = !is_last;
               end else if (run_done) begin
                  state_nx = ST_PASS;
               end
            end
            ST_RESTART: state_nx = ST_RUN;
            default:    state_nx = state;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   assign busy         = (state == ST_RUN) || (state == ST_RESTART);
   assign restart      = (state == ST_RESTART);
   assign repair_ok    = (state == ST_PASS);
   assign unrepairable = (state == ST_FAIL);

   ssa_strategy_seq #(.T(T), .NCOL(COLS_SP), .SIW(SIW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_first (load_first),
      .advance    (advance),
      .code       (strat_code),
      .idx        (strat_idx),
      .is_last    (is_last)
   );

   ssa_spare_alloc #(.NROW(ROWS_SP), .NCOL(COLS_SP), .RAW(ROW_AW), .WW(WORD_W)) u_alloc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .enable     (state == ST_RUN && !start),
      .fail_vld   (fail_vld),
      .fail_row   (fail_row),
      .fail_bits  (fail_bits),
      .code       (strat_code),
      .crv        (crv),
      .row_list   (row_list),
      .row_used   (row_used),
      .strat_fail (strat_fail)
   );
endmodule

// File: rtl/ssa_checker.sv
module ssa_checker #(
   parameter int ROWS_SP = 2,
   parameter int COLS_SP = 2,
   parameter int ROW_AW  = 4,
   parameter int WORD_W  = 5,
   parameter int SIW     = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      start,
   input logic                      fail_vld,
   input logic [WORD_W-1:0]         fail_bits,
   input logic                      busy,
   input logic                      restart,
   input logic                      repair_ok,
   input logic                      unrepairable,
   input logic [SIW-1:0]            strat_idx,
   input logic [WORD_W-1:0]         crv,
   input logic [ROWS_SP*ROW_AW-1:0] row_list,
   input logic [ROWS_SP-1:0]        row_used
);
   a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (crv == '0) && (row_used == '0) && (strat_idx == '0) && busy);

   a_r3_covered_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !restart && !start && fail_vld && (|fail_bits) && ((fail_bits & ~crv) == '0))
      |=> $stable(crv) && $stable(row_used));

   a_r6_crv_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(crv) <= COLS_SP));

   a_r7_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !restart && busy);

   a_r8_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (repair_ok && !start) |=> repair_ok && $stable(crv) && $stable(row_list));

   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(repair_ok && unrepairable));
endmodule

bind spare_sweep_analyzer ssa_checker #(
   .ROWS_SP(ROWS_SP), .COLS_SP(COLS_SP), .ROW_AW(ROW_AW), .WORD_W(WORD_W), .SIW(SIW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .fail_vld(fail_vld), .fail_bits(fail_bits),
   .busy(busy), .restart(restart), .repair_ok(repair_ok), .unrepairable(unrepairable),
   .strat_idx(strat_idx), .crv(crv), .row_list(row_list), .row_used(row_used)
);

// File: tb/spare_sweep_analyzer_test.sv
module spare_sweep_analyzer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, fail_vld = 1'b0, run_done = 1'b0;
   logic [3:0] fail_row = '0;
   logic [4:0] fail_bits = '0;
   logic       busy, restart, repair_ok, unrepairable;
   logic [3:0] strat_code;
   logic [2:0] strat_idx;
   logic [4:0] crv;
   logic [7:0] row_list;
   logic [1:0] row_used;

   int nchk = 0, nbad = 0;
   logic [3:0] pr [8];
   logic [4:0] pb [8];
   int np = 0;

   always #10 clk = ~clk;   // 50 MHz

   spare_sweep_analyzer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .fail_vld(fail_vld), .fail_row(fail_row),
      .fail_bits(fail_bits), .run_done(run_done), .busy(busy), .restart(restart),
      .repair_ok(repair_ok), .unrepairable(unrepairable), .strat_code(strat_code),
      .strat_idx(strat_idx), .crv(crv), .row_list(row_list), .row_used(row_used)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic feed(input logic [3:0] r, input logic [4:0] b, input logic v);
      fail_vld = v; fail_row = r; fail_bits = b;
      @(negedge clk);
      fail_vld = 1'b0; fail_bits = '0;
   endtask

   task automatic kick();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // play pattern pr/pb; returns on restart/unrepairable, else finishes with run_done
   task automatic play(output bit rs, output bit ur);
      rs = 0; ur = 0;
      for (int i = 0; i < np; i++) begin
         feed(pr[i], pb[i], 1'b1);
         if (restart) begin rs = 1; @(negedge clk); return; end
         if (unrepairable) begin ur = 1; return; end
      end
      run_done = 1'b1;
      @(negedge clk);
      run_done = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 busy after reset", busy, 0);
      chk("R1 restart after reset", restart, 0);
      chk("R1 ok/unrep after reset", {repair_ok, unrepairable}, 0);
      kick();
      chk("R1 busy after start", busy, 1);
      chk("R1 idx after start", strat_idx, 0);
      chk("R10 first code RRCC", strat_code, 4'b0011);
      chk("R1 crv cleared", crv, 0);
      chk("R1 rows cleared", row_used, 0);
   endtask

   task automatic t_cover();
      kick();
      feed(4'd4, 5'b00011, 1'b1);
      chk("R2 row slot0 used", row_used, 2'b01);
      chk("R2 row slot0 addr", row_list[3:0], 4);
      chk("R2 crv untouched by row token", crv, 0);
      feed(4'd4, 5'b10000, 1'b1);
      chk("R3 same row covered", {row_used, crv}, {2'b01, 5'b0});
      feed(4'd6, 5'b00100, 1'b1);
      chk("R2 row slot1", {row_used, row_list[7:4]}, {2'b11, 4'd6});
      feed(4'd7, 5'b01000, 1'b1);
      chk("R2 column token merges", crv, 5'b01000);
      feed(4'd8, 5'b01000, 1'b1);
      chk("R3 covered by crv", {crv, restart}, {5'b01000, 1'b0});
      feed(4'd9, 5'b00000, 1'b1);
      chk("R4 zero bits ignored", {crv, restart}, {5'b01000, 1'b0});
      feed(4'd10, 5'b10000, 1'b0);
      chk("R4 fail_vld low ignored", {crv, restart}, {5'b01000, 1'b0});
      run_done = 1'b1; @(negedge clk); run_done = 1'b0;
      chk("R8 repair_ok", {repair_ok, busy}, 2'b10);
      chk("R8 result rows", row_list, {4'd6, 4'd4});
      feed(4'd11, 5'b00001, 1'b1);
      chk("R8 held after done", {repair_ok, crv}, {1'b1, 5'b01000});
   endtask

   task automatic t_sweep();
      bit rs, ur;
      logic [3:0] exp_code [4] = '{4'b0011, 4'b0101, 4'b0110, 4'b1001};
      kick();
      np = 3;
      pr[0] = 4'd1; pb[0] = 5'b10001;
      pr[1] = 4'd2; pb[1] = 5'b01110;
      pr[2] = 4'd3; pb[2] = 5'b01110;
      for (int s = 0; s < 3; s++) begin
         chk("R10 code before run", strat_code, exp_code[s]);
         play(rs, ur);
         chk("R6 overflow restarts", rs, 1);
         chk("R7 state cleared", {crv, row_used, busy}, {5'b0, 2'b0, 1'b1});
         chk("R10 next index", strat_idx, s + 1);
      end
      play(rs, ur);
      chk("R8 CRRC succeeds", {rs, repair_ok}, 2'b01);
      chk("R8 CRRC crv", crv, 5'b10001);
      chk("R8 CRRC rows", {row_used, row_list}, {2'b11, 4'd3, 4'd2});
      chk("R10 CRRC code", strat_code, 4'b1001);
   endtask

   task automatic t_unrep();
      bit rs, ur;
      int nrs;
      nrs = 0; ur = 0;
      kick();
      np = 5;
      for (int i = 0; i < 5; i++) begin pr[i] = 4'(i + 1); pb[i] = 5'(1 << i); end
      for (int s = 0; s < 6 && !ur; s++) begin
         play(rs, ur);
         if (rs) nrs++;
      end
      chk("R5 exhaustion restarts", nrs, 5);
      chk("R9 unrepairable", {unrepairable, repair_ok, busy, restart}, 4'b1000);
      chk("R10 last index", {strat_idx, strat_code}, {3'd5, 4'b1100});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog (R1..R10 run) act=hung exp=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cover();
      t_sweep();
      t_unrep();
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end
endmodule